// File: doc/BRIEF.md
# Overlapping Serial Pattern Detector

This block watches a serial bit stream that arrives at one bit per clock. A qualifier input marks which clock cycles carry a real bit. Each time the last six qualified bits form the pattern 1,1,0,0,1,1, the block raises a one-cycle match flag. The first bit received is the leftmost bit of the pattern. Matches may overlap: the final two ones of one match can serve as the opening two ones of the next.

Inside, a synchronous state machine records how many leading pattern bits the recent input has matched. It holds a prefix length from 0 to 5. When a bit breaks a partial match, the machine falls back to the longest prefix of the pattern that is also a suffix of the bits seen so far. A completed match leaves the machine in the "11" state. The pattern and its length are elaboration-time parameters, and the fallback lengths are computed from them. The pattern cannot be changed at runtime.

Top module: `pattern_spotter`

## Requirements
- R1: While `rstN` is low, `match` is low and the machine is at prefix length 0. After release, no match can come from any bit received before or during reset.
- R2: When a qualified bit completes the pattern 110011 (the first-received bit is the pattern's bit 5, the MSB), `match` is high in the cycle that follows that clock edge. It is high for exactly one cycle.
- R3: Matches overlap. Right after a match, the qualified bits 0,0,1,1 complete another match.
- R4: On a mismatching bit, the machine keeps the longest pattern prefix that is a suffix of the received bits. For example, 1,1,1,0,0,1,1 produces a match on its last bit.
- R5: Bit sequences that differ from the pattern in any one position never raise `match`.
- R6: A cycle with `inValid` low leaves the prefix state unchanged, whatever value `inBit` has. `match` is low in the following cycle.
- R7: For any stream, `match` is high after a qualified bit exactly when the last six qualified bits received since reset equal 110011.
- R8: Asserting reset in the middle of a partial match discards it. After 1,1,0,0,1, then reset, then 1, there is no match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock; the state and output registers update on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | High when `inBit` carries a stream bit this cycle |
| inBit | input | 1 | Serial data bit |
| match | output | 1 | Registered flag, high for one cycle after the pattern completes |

## Verification
The assertions assume that `inValid` and `inBit` are stable at each rising clock edge. They also assume that reset is released away from a clock edge with `inValid` low. The stimulus drives all inputs at the falling edge, including reset assertion and release, and keeps `inValid` low while reset is active. With those inputs, the one-cycle pulse, the idle hold and the reset clear can be checked as plain clocked properties.

// File: rtl/spot_pkg.sv
package spot_pkg;

  // Strobes from the control to the output datapath.
  typedef struct packed {
    logic advance;  // a qualified bit is consumed this cycle
    logic hit;      // the current bit would complete the pattern
  } spotStrobe_t;

  // Pattern bit at stream position idx (idx 0 is received first).
  function automatic logic patAt(int idx, int patLen, logic [31:0] pat);
    return pat[5'(patLen - 1 - idx)];
  endfunction

  // Longest k so that the first k pattern bits equal the last k bits of
  // (first len pattern bits followed by b).
  function automatic int nextLen(int len, logic b, int patLen, logic [31:0] pat);
    int best;
    int pos;
    logic ok;
    logic rb;
    best = 0;
    for (int k = 1; k <= 32; k++) begin
      if (k <= len + 1 && k <= patLen) begin
        ok = 1'b1;
        for (int i = 0; i < 32; i++) begin
          if (i < k) begin
            pos = len + 1 - k + i;
            rb  = (pos == len) ? b : patAt(pos, patLen, pat);
            if (rb != patAt(i, patLen, pat)) ok = 1'b0;
          end
        end
        if (ok) best = k;
      end
    end
    return best;
  endfunction

  // Longest proper prefix of the pattern that is also its suffix.
  function automatic int border(int patLen, logic [31:0] pat);
    int best;
    logic ok;
    best = 0;
    for (int k = 1; k < 32; k++) begin
      if (k < patLen) begin
        ok = 1'b1;
        for (int i = 0; i < 32; i++) begin
          if (i < k) begin
            if (patAt(i, patLen, pat) != patAt(patLen - k + i, patLen, pat)) ok = 1'b0;
          end
        end
        if (ok) best = k;
      end
    end
    return best;
  endfunction

endpackage

// File: rtl/spot_ctrl.sv
module spot_ctrl
  import spot_pkg::*;
#(
  parameter int PAT_LEN = 6,
  parameter logic [PAT_LEN-1:0] PATTERN = 6'b110011,
  parameter int LW = $clog2(PAT_LEN + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inBit,
  output spotStrobe_t   strobe,
  output logic [LW-1:0] prefixLen
);

  localparam logic [31:0] PAT32   = 32'(PATTERN);
  localparam int          RESTART = border(PAT_LEN, PAT32);

  logic [LW-1:0] stateQ;
  logic [LW-1:0] stateD;
  int            cand;

  always_comb begin
    cand          = nextLen(int'(stateQ), inBit, PAT_LEN, PAT32);
    strobe.hit     = (cand == PAT_LEN);
    strobe.advance = inValid;
    stateD        = stateQ;
    if (inValid) begin
      if (strobe.hit) stateD = LW'(RESTART);
      else            stateD = LW'(cand);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= '0;
    else       stateQ <= stateD;
  end

  assign prefixLen = stateQ;

endmodule

// File: rtl/spot_dp.sv
module spot_dp
  import spot_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  spotStrobe_t strobe,
  output logic        matchQ
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchQ <= 1'b0;
    else       matchQ <= strobe.advance & strobe.hit;
  end

endmodule

// File: rtl/pattern_spotter.sv
module pattern_spotter
  import spot_pkg::*;
#(
  parameter int PAT_LEN = 6,
  parameter logic [PAT_LEN-1:0] PATTERN = 6'b110011
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic inBit,
  output logic match
);

  localparam int LW = $clog2(PAT_LEN + 1);

  spotStrobe_t   strobe;
  logic [LW-1:0] prefixLen;

  spot_ctrl #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN), .LW(LW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inBit     (inBit),
    .strobe    (strobe),
    .prefixLen (prefixLen)
  );

  spot_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .matchQ (match)
  );

endmodule

// File: rtl/spot_checker.sv
module spot_checker #(
  parameter int PAT_LEN = 6,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic          inBit,
  input logic          match,
  input logic [LW-1:0] prefixLen
);

  // R1: reset holds the machine empty and the flag low
  a_r1_reset_clears: assert property (@(posedge clk)
    !rstN |=> (!match && prefixLen == '0));

  // R2: the flag never lasts two cycles
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    match |=> !match);

  // R2: a flag follows a qualified 1
  a_r2_needs_one: assert property (@(posedge clk) disable iff (!rstN)
    match |-> ($past(inValid) && $past(inBit)));

  // R6: an unqualified cycle keeps the state and gives no flag
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(prefixLen) && !match));

  // R4: the prefix length stays below the full pattern length
  a_r4_prefix_range: assert property (@(posedge clk) disable iff (!rstN)
    int'(prefixLen) < PAT_LEN);

endmodule

bind pattern_spotter spot_checker #(.PAT_LEN(PAT_LEN), .LW(LW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inBit     (inBit),
  .match     (match),
  .prefixLen (prefixLen)
);

// File: tb/sim_pattern_spotter.sv
module sim_pattern_spotter;

  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] PAT = 6'b110011;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inBit = 1'b0;
  logic match;

  int errors = 0;
  int checks = 0;
  logic [5:0] hist = '0;
  int seen = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pattern_spotter u0 (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inBit   (inBit),
    .match   (match)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: match=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle of input at the falling edge and check the flag one edge later.
  task automatic sendBit(string req, logic v, logic b);
    logic exp;
    inValid = v;
    inBit   = b;
    if (v) begin
      hist = {hist[4:0], b};
      seen++;
    end
    exp = v && seen >= 6 && hist == PAT;
    @(negedge clk);
    check(req, match, exp);
  endtask

  task automatic sendSeq(string req, int n, logic [31:0] bits);
    for (int i = n - 1; i >= 0; i--) sendBit(req, 1'b1, bits[i]);
  endtask

  task automatic doReset();
    inValid = 1'b0;
    rstN = 1'b0;
    hist = '0;
    seen = 0;
    @(negedge clk);
    check("R1", match, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", match, 1'b0);
  endtask

  task automatic testSingle();
    doReset();
    sendSeq("R2", 6, 32'b110011);
    sendBit("R2", 1'b1, 1'b0);   // pulse lasts one cycle
  endtask

  task automatic testOverlap();
    doReset();
    sendSeq("R3", 10, 32'b1100110011);
    sendSeq("R3", 4, 32'b0011);
  endtask

  task automatic testFallback();
    doReset();
    sendSeq("R4", 7, 32'b1110011);
    sendSeq("R4", 9, 32'b110110011);
  endtask

  task automatic testNearMiss();
    doReset();
    for (int p = 0; p < 6; p++) begin
      sendSeq("R5", 6, 32'(PAT ^ (6'b1 << p)));
      sendSeq("R5", 2, 32'b00);
    end
  endtask

  task automatic testIdle();
    doReset();
    sendSeq("R6", 3, 32'b110);
    sendBit("R6", 1'b0, 1'b1);
    sendBit("R6", 1'b0, 1'b1);
    sendBit("R6", 1'b1, 1'b0);
    sendBit("R6", 1'b0, 1'b0);
    sendBit("R6", 1'b1, 1'b1);
    sendBit("R6", 1'b0, 1'b0);
    sendBit("R6", 1'b1, 1'b1);
    sendBit("R6", 1'b0, 1'b1);
  endtask

  task automatic testMidReset();
    doReset();
    sendSeq("R8", 5, 32'b11001);
    doReset();
    sendBit("R8", 1'b1, 1'b1);
    sendSeq("R8", 5, 32'b10011);
  endtask

  task automatic testStream();
    logic [15:0] lfsr = 16'hACE1;
    doReset();
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sendBit("R7", lfsr[3] | lfsr[7], lfsr[0] | lfsr[5]);
    end
  endtask

  initial begin
    @(negedge clk);
    check("R1", match, 1'b0);
    testSingle();
    testOverlap();
    testFallback();
    testNearMiss();
    testIdle();
    testMidReset();
    testStream();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule